// File: doc/BRIEF.md
# External Interrupt Pin Latch

This block turns one active-low external interrupt pin into a latched interrupt request for a CPU. The pin is first brought into the clock domain through a short synchronizer. A falling edge on the synchronized pin then sets a pending latch. Software selects how the latch is released. In edge mode, any acknowledge releases it. In level-hold mode, the latch also waits for the pin to return high, and the acknowledge and the pin's return may arrive in either order.

A one-byte control/status register controls the block and reports its state. It holds the sensitivity select and a local mask. It also decodes a write-one acknowledge bit and reports the pending flag. A vector-fetch acknowledge strobe from the CPU clears the latch in the same way as a software acknowledge. The forwarded request is gated by the local mask and by the CPU's global interrupt mask. Neither mask stops the latch from recording an event.

Top module: `extint_latch`

## Requirements
- R1: While reset is asserted and directly after it, the register reads 8'h00 and `irq_o` is 0.
- R2: A high-to-low transition on `pin_ni` sets the pending flag (register bit 3) exactly three clock edges after the pin changes. Without an edge the flag never sets.
- R3: In edge mode (bit 0 = 0), the pending flag stays set after the pin returns high until an acknowledge. A pin that stays low after an acknowledge does not set the flag again.
- R4: In edge mode, a one-cycle `vec_ack_i` pulse clears the pending flag at the next clock edge.
- R5: A register write with bit 2 = 1 clears the pending flag at that edge. Bit 2 always reads 0.
- R6: In level-hold mode (bit 0 = 1), an acknowledge given while the pin is low leaves the flag set. The flag clears three clock edges after the pin returns high.
- R7: In level-hold mode, if the pin is already high, the flag stays set without an acknowledge and clears at the edge of the acknowledge.
- R8: When the local mask (bit 1) is 1, `irq_o` is 0 while the pending flag still reads 1.
- R9: When `cpu_mask_i` is 1, `irq_o` is 0. Otherwise `irq_o` equals pending AND NOT local mask.
- R10: A falling edge that is detected in the same cycle as an acknowledge leaves the flag set.
- R11: Reset clears the pending flag and returns bit 0 to edge mode. No request appears after reset while the pin is held low.
- R12: Bits 0 and 1 are read/write. Writes to bits 3 to 7 are ignored, and bits 2 and 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| pin_ni | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| vec_ack_i | input | 1 | Vector-fetch acknowledge strobe |
| cpu_mask_i | input | 1 | CPU global interrupt mask |
| irq_o | output | 1 | Forwarded interrupt request |

## Verification
The assertions check the following on every cycle:
- No mask lets a request through.
- The flag never rises without a detected edge.
- A detected edge always sets the flag, even against an acknowledge.
- A vector acknowledge in edge mode always clears.
- Level-hold mode never releases while the synchronized pin is low.

Some behaviours need ordered scenarios, so only the bench shows them:
- The exact three-edge latency.
- Both orders of acknowledge and pin release.
- The fact that a held-low pin does not re-arm after an acknowledge or after reset.
- The register readback.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_MODE  = 0;
    localparam int BIT_IMASK = 1;
    localparam int BIT_ACK   = 2;
    localparam int BIT_FLAG  = 3;

    typedef struct packed {
        logic mode;
        logic imask;
    } ctrl_t;

    typedef struct packed {
        logic pend;
        logic ack_seen;
    } core_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic level_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    assign st_d.chain[0] = pin_ni;

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            assign st_d.chain[i] = st_q.chain[i-1];
        end
    endgenerate

    always_comb begin
        st_d.prev = st_q.chain[STAGES-1];
    end

    // Reset to the asserted level so a pin held low through reset is no edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.chain[STAGES-1];
    assign fall_o  = st_q.prev & ~st_q.chain[STAGES-1];
endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             mode_o,
    output logic             imask_o,
    output logic             sw_ack_o
);
    ctrl_t ctl_d, ctl_q;
    logic  unused_wbits;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) begin
            ctl_d.mode  = wdata_i[BIT_MODE];
            ctl_d.imask = wdata_i[BIT_IMASK];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign mode_o       = ctl_q.mode;
    assign imask_o      = ctl_q.imask;
    assign sw_ack_o     = wr_i & wdata_i[BIT_ACK];
    assign unused_wbits = ^wdata_i;
endmodule

// File: rtl/extint_core.sv
module extint_core
    import extint_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fall_i,
    input  logic level_i,
    input  logic mode_i,
    input  logic ack_i,
    output logic pend_o
);
    core_t cs_d, cs_q;
    logic  ack_hit;

    always_comb begin
        cs_d    = cs_q;
        ack_hit = ack_i | cs_q.ack_seen;
        if (fall_i) begin
            cs_d.pend     = 1'b1;
            cs_d.ack_seen = 1'b0;
        end else if (cs_q.pend) begin
            if (!mode_i) begin
                cs_d.pend     = ~ack_i;
                cs_d.ack_seen = 1'b0;
            end else if (ack_hit && level_i) begin
                cs_d.pend     = 1'b0;
                cs_d.ack_seen = 1'b0;
            end else begin
                cs_d.ack_seen = ack_hit;
            end
        end else begin
            cs_d.ack_seen = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cs_q <= '0;
        else         cs_q <= cs_d;
    end

    assign pend_o = cs_q.pend;
endmodule

// File: rtl/extint_latch.sv
module extint_latch
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_ni,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             vec_ack_i,
    input  logic             cpu_mask_i,
    output logic             irq_o
);
    logic pin_level, edge_fall;
    logic mode, imask, sw_ack, pend;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_ni  (pin_ni),
        .level_o (pin_level),
        .fall_o  (edge_fall)
    );

    extint_regs u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .mode_o   (mode),
        .imask_o  (imask),
        .sw_ack_o (sw_ack)
    );

    extint_core u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fall_i  (edge_fall),
        .level_i (pin_level),
        .mode_i  (mode),
        .ack_i   (vec_ack_i | sw_ack),
        .pend_o  (pend)
    );

    always_comb begin
        reg_rdata_o            = '0;
        reg_rdata_o[BIT_MODE]  = mode;
        reg_rdata_o[BIT_IMASK] = imask;
        reg_rdata_o[BIT_FLAG]  = pend;
    end

    assign irq_o = pend & ~imask & ~cpu_mask_i;
endmodule

// File: rtl/extint_latch_chk.sv
module extint_latch_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic irq_o,
    input logic mode,
    input logic imask,
    input logic flag,
    input logic vec_ack_i,
    input logic cpu_mask_i,
    input logic fall,
    input logic pin_lvl
);
    a_r8_imask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        imask |-> !irq_o);

    a_r9_cpu_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_mask_i |-> !irq_o);

    a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag && !fall) |=> !flag);

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall |=> flag);

    a_r4_vec_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode && vec_ack_i && !fall) |=> !flag);

    a_r6_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode && flag && !pin_lvl) |=> flag);
endmodule

bind extint_latch extint_latch_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_o      (irq_o),
    .mode       (reg_rdata_o[0]),
    .imask      (reg_rdata_o[1]),
    .flag       (reg_rdata_o[3]),
    .vec_ack_i  (vec_ack_i),
    .cpu_mask_i (cpu_mask_i),
    .fall       (edge_fall),
    .pin_lvl    (pin_level)
);

// File: tb/tb_extint_latch.sv
module tb_extint_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rdata;
    logic       vec_ack = 1'b0;
    logic       cpu_mask = 1'b0;
    logic       irq;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    extint_latch dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_ni      (pin_n),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (rdata),
        .vec_ack_i   (vec_ack),
        .cpu_mask_i  (cpu_mask),
        .irq_o       (irq)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic vack();
        vec_ack = 1'b1;
        step(1);
        vec_ack = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        check("R1 reset rdata", rdata, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        step(3);
        check("R1 after reset", rdata, 8'h00);

        // R12: sweep mode/imask with junk in the upper and flag bits
        for (int k = 0; k < 4; k++) begin
            wr(8'hF8 | 8'(k));
            check("R12 readback", rdata, 8'(k));
        end
        wr(8'h00);

        // R2: latency of three edges
        pin_n = 1'b0;
        step(2);
        check("R2 not yet", rdata, 8'h00);
        step(1);
        check("R2 set", rdata, 8'h08);
        check("R2 irq", {7'd0, irq}, 8'h01);

        // R3: stays set after pin returns high
        pin_n = 1'b1;
        step(5);
        check("R3 held", rdata, 8'h08);

        // R4: vector acknowledge clears
        vack();
        check("R4 cleared", rdata, 8'h00);
        check("R4 irq", {7'd0, irq}, 8'h00);

        // R3: held-low pin does not re-set after ack
        pin_n = 1'b0;
        step(3);
        check("R3 set again", rdata, 8'h08);
        vack();
        step(5);
        check("R3 no re-arm", rdata, 8'h00);

        // R5: software acknowledge
        pin_n = 1'b1;
        step(3);
        pin_n = 1'b0;
        step(3);
        check("R5 set", rdata, 8'h08);
        wr(8'h04);
        check("R5 sw clear", rdata, 8'h00);

        // R8/R9: mask sweep on a pending request
        pin_n = 1'b1;
        step(3);
        pin_n = 1'b0;
        step(3);
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 2; c++) begin
                wr(8'(m << 1));
                cpu_mask = c[0];
                #1;
                check("R8 flag kept", {4'd0, rdata[3], 3'd0}, 8'h08);
                check("R9 irq gating", {7'd0, irq}, {7'd0, (m == 0) && (c == 0)});
            end
        end
        cpu_mask = 1'b0;
        wr(8'h04);

        // R6: level-hold, ack while low, then pin release
        wr(8'h01);
        pin_n = 1'b1;
        step(3);
        pin_n = 1'b0;
        step(3);
        check("R6 set", rdata, 8'h09);
        vack();
        step(4);
        check("R6 hold low", rdata, 8'h09);
        pin_n = 1'b1;
        step(2);
        check("R6 sync delay", rdata, 8'h09);
        step(1);
        check("R6 release", rdata, 8'h01);

        // R7: pin high first, then ack
        pin_n = 1'b0;
        step(3);
        check("R7 set", rdata, 8'h09);
        pin_n = 1'b1;
        step(5);
        check("R7 wait ack", rdata, 8'h09);
        wr(8'h05);
        check("R7 ack clears", rdata, 8'h01);

        // R10: edge and ack in the same cycle
        wr(8'h00);
        pin_n = 1'b0;
        step(3);
        pin_n = 1'b1;
        step(3);
        pin_n = 1'b0;
        step(2);
        vack();
        check("R10 set wins", rdata, 8'h08);
        vack();
        check("R10 cleared", rdata, 8'h00);

        // R11: reset with pin low in level-hold mode
        wr(8'h01);
        pin_n = 1'b1;
        step(3);
        pin_n = 1'b0;
        step(3);
        check("R11 pending", rdata, 8'h09);
        rst_n = 1'b0;
        step(1);
        check("R11 in reset", rdata, 8'h00);
        rst_n = 1'b1;
        step(5);
        check("R11 after reset", rdata, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule